// File: doc/BRIEF.md
# I2C Master Acknowledge and Stop Sequencer

This block is the bus-level engine of an I2C master that sends the acknowledge bit after a received byte and that closes a transfer with a Stop condition. Both lines are open-drain. The block drives an output enable for each line, where 0 pulls the line low and 1 releases it. It reads both lines back through a synchronizer. Every timed phase is measured by a reloadable baud-rate down-counter. That counter starts only after the line just changed has been read back at its intended level, so a slave that holds SCL low stretches the phase instead of shortening it.

Software starts a sequence with a one-cycle strobe. `ack_go` starts an acknowledge, and `ack_bit` chooses the value sent. `stop_go` starts a Stop. The matching enable (`ack_active` or `stop_active`) clears itself when the sequence ends, and at that point a sticky interrupt flag is raised. A completed Stop also sets a stop-seen status bit. A write to the transmit buffer while a sequence is running is refused and raises a sticky collision flag.

Top module: `i2c_ackstop_seq`

## Requirements
- R1: After reset both enables are 1 (released). `stop_seen`, `irq_flag`, `wcol_flag`, `ack_active` and `stop_active` are 0, and `buf_q` is 0.
- R2: An `ack_go` in idle drives `scl_oe`=0 and `sda_oe`=`ack_bit` (0 = ACK, 1 = NACK) for exactly `reload`+1 cycles. It then releases SCL.
- R3: The acknowledge high phase lasts `reload`+1 cycles, counted only after SCL reads back high. With a two-stage synchronizer, `scl_oe` stays 1 for `reload`+4 cycles when nothing stretches the clock. When a slave holds SCL low, the phase lasts `reload`+3 cycles after the half cycle in which SCL is released.
- R4: At the end of the acknowledge, `scl_oe` returns to 0, `ack_active` clears and `irq_flag` is set in the same cycle.
- R5: A `stop_go` in idle drives `sda_oe`=0. Once SDA reads back low, one baud period (`reload`+1 cycles) is counted and SCL is released. When SDA was already low, this phase lasts `reload`+2 cycles. When SDA was released, it lasts `reload`+4 cycles.
- R6: In a Stop, once SCL reads back high, one baud period is counted and then SDA is released. SDA is never released while `scl_oe` is 0. This phase lasts `reload`+4 cycles.
- R7: `stop_seen` is set 3 cycles after SDA is released, once both lines read back high. `stop_active` clears and `irq_flag` is set `reload`+1 cycles after that. `stop_seen` clears when the next sequence starts.
- R8: `buf_wr` while a sequence is active sets `wcol_flag` and leaves `buf_q` unchanged.
- R9: `irq_flag` and `wcol_flag` stay set until a cycle with `irq_clr` or `wcol_clr` high clears them. A set in the same cycle as a clear wins.
- R10: `ack_go` or `stop_go` while a sequence is active is ignored. When both arrive together in idle, the acknowledge starts.
- R11: `buf_wr` in idle loads `buf_wdata` into `buf_q` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload | input | CNT_W | Baud-rate reload value; one period is reload+1 cycles |
| ack_go | input | 1 | Strobe: start an acknowledge sequence |
| ack_bit | input | 1 | Acknowledge value: 0 = ACK, 1 = NACK |
| stop_go | input | 1 | Strobe: start a Stop sequence |
| buf_wr | input | 1 | Transmit-buffer write strobe |
| buf_wdata | input | BUF_W | Transmit-buffer write data |
| irq_clr | input | 1 | Clear the interrupt flag |
| wcol_clr | input | 1 | Clear the write-collision flag |
| sda_in | input | 1 | SDA line level (asynchronous) |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_oe | output | 1 | SDA enable: 0 drives low, 1 releases |
| scl_oe | output | 1 | SCL enable: 0 drives low, 1 releases |
| ack_active | output | 1 | Acknowledge sequence in progress |
| stop_active | output | 1 | Stop sequence in progress |
| stop_seen | output | 1 | Stop condition completed on the bus |
| irq_flag | output | 1 | Sticky sequence-done interrupt flag |
| wcol_flag | output | 1 | Sticky write-collision flag |
| buf_q | output | BUF_W | Transmit-buffer contents |

## Verification
The assertions check the following properties on every cycle:
- While the acknowledge low phase lasts, the lines match the stored `ack_bit`.
- A wait on SCL read-back never advances without a high sample.
- A Stop never releases SDA while SCL is driven low.
- `stop_seen` rises only after both lines read high.
- A busy-time buffer write is rejected.
- The sticky flags hold.
- A request made during a Stop cannot start an acknowledge.

Some behaviour can only be shown by the bench's scenarios, because it depends on the counted delay and on the bus model:
- the exact length of each phase for different reload values;
- the length of a clock-stretched high phase;
- the shorter first Stop phase when SDA is already low;
- the priority between simultaneous requests.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK_LOW,
        ST_ACK_REL,
        ST_ACK_HIGH,
        ST_STP_SDA,
        ST_STP_LOW,
        ST_STP_SCLW,
        ST_STP_HIGH,
        ST_STP_REL,
        ST_STP_END
    } seq_state_e;

    function automatic logic is_ack_state(seq_state_e s);
        return (s == ST_ACK_LOW) || (s == ST_ACK_REL) || (s == ST_ACK_HIGH);
    endfunction

    function automatic logic is_stop_state(seq_state_e s);
        return (s == ST_STP_SDA) || (s == ST_STP_LOW) || (s == ST_STP_SCLW) ||
               (s == ST_STP_HIGH) || (s == ST_STP_REL) || (s == ST_STP_END);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '1;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_baud_counter.sv
module i2c_baud_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic             done
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } brg_t;

    brg_t brg_d, brg_q;

    assign done = brg_q.run && (brg_q.cnt == '0);

    always_comb begin
        brg_d = brg_q;
        if (load) begin
            brg_d.run = 1'b1;
            brg_d.cnt = reload;
        end else if (done) begin
            brg_d.run = 1'b0;
        end else if (brg_q.run) begin
            brg_d.cnt = brg_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brg_q <= '0;
        end else begin
            brg_q <= brg_d;
        end
    end

    // R3: one rollover is a single done pulse, then the counter is off
    p_brg_single_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && !load |=> !done);

endmodule

// File: rtl/i2c_ackstop_seq.sv
module i2c_ackstop_seq
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int BUF_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    input  logic             ack_go,
    input  logic             ack_bit,
    input  logic             stop_go,
    input  logic             buf_wr,
    input  logic [BUF_W-1:0] buf_wdata,
    input  logic             irq_clr,
    input  logic             wcol_clr,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_oe,
    output logic             scl_oe,
    output logic             ack_active,
    output logic             stop_active,
    output logic             stop_seen,
    output logic             irq_flag,
    output logic             wcol_flag,
    output logic [BUF_W-1:0] buf_q
);
    typedef struct packed {
        seq_state_e       st;
        logic             sda_oe;
        logic             scl_oe;
        logic             ack_bit;
        logic             stop_seen;
        logic             irq;
        logic             wcol;
        logic [BUF_W-1:0] buf_data;
    } seq_t;

    seq_t       seq_d, seq_q;
    logic       brg_load;
    logic       brg_done;
    logic [1:0] line_s;
    logic       sda_s;
    logic       scl_s;
    logic       busy;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES),
        .WIDTH (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({sda_in, scl_in}),
        .sync_out(line_s)
    );

    assign sda_s = line_s[1];
    assign scl_s = line_s[0];

    i2c_baud_counter #(
        .CNT_W(CNT_W)
    ) u_brg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (brg_load),
        .reload(reload),
        .done  (brg_done)
    );

    assign busy = (seq_q.st != ST_IDLE);

    always_comb begin
        seq_d    = seq_q;
        brg_load = 1'b0;

        if (irq_clr) begin
            seq_d.irq = 1'b0;
        end
        if (wcol_clr) begin
            seq_d.wcol = 1'b0;
        end

        if (buf_wr) begin
            if (busy) begin
                seq_d.wcol = 1'b1;
            end else begin
                seq_d.buf_data = buf_wdata;
            end
        end

        unique case (seq_q.st)
            ST_IDLE: begin
                if (ack_go) begin
                    seq_d.st        = ST_ACK_LOW;
                    seq_d.scl_oe    = 1'b0;
                    seq_d.sda_oe    = ack_bit;
                    seq_d.ack_bit   = ack_bit;
                    seq_d.stop_seen = 1'b0;
                    brg_load        = 1'b1;
                end else if (stop_go) begin
                    seq_d.st        = ST_STP_SDA;
                    seq_d.sda_oe    = 1'b0;
                    seq_d.stop_seen = 1'b0;
                end
            end
            ST_ACK_LOW: begin
                if (brg_done) begin
                    seq_d.scl_oe = 1'b1;
                    seq_d.st     = ST_ACK_REL;
                end
            end
            ST_ACK_REL: begin
                if (scl_s) begin
                    brg_load = 1'b1;
                    seq_d.st = ST_ACK_HIGH;
                end
            end
            ST_ACK_HIGH: begin
                if (brg_done) begin
                    seq_d.scl_oe = 1'b0;
                    seq_d.irq    = 1'b1;
                    seq_d.st     = ST_IDLE;
                end
            end
            ST_STP_SDA: begin
                if (!sda_s) begin
                    brg_load = 1'b1;
                    seq_d.st = ST_STP_LOW;
                end
            end
            ST_STP_LOW: begin
                if (brg_done) begin
                    seq_d.scl_oe = 1'b1;
                    seq_d.st     = ST_STP_SCLW;
                end
            end
            ST_STP_SCLW: begin
                if (scl_s) begin
                    brg_load = 1'b1;
                    seq_d.st = ST_STP_HIGH;
                end
            end
            ST_STP_HIGH: begin
                if (brg_done) begin
                    seq_d.sda_oe = 1'b1;
                    seq_d.st     = ST_STP_REL;
                end
            end
            ST_STP_REL: begin
                if (sda_s && scl_s) begin
                    seq_d.stop_seen = 1'b1;
                    brg_load        = 1'b1;
                    seq_d.st        = ST_STP_END;
                end
            end
            ST_STP_END: begin
                if (brg_done) begin
                    seq_d.irq = 1'b1;
                    seq_d.st  = ST_IDLE;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st        <= ST_IDLE;
            seq_q.sda_oe    <= 1'b1;
            seq_q.scl_oe    <= 1'b1;
            seq_q.ack_bit   <= 1'b0;
            seq_q.stop_seen <= 1'b0;
            seq_q.irq       <= 1'b0;
            seq_q.wcol      <= 1'b0;
            seq_q.buf_data  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sda_oe      = seq_q.sda_oe;
    assign scl_oe      = seq_q.scl_oe;
    assign ack_active  = is_ack_state(seq_q.st);
    assign stop_active = is_stop_state(seq_q.st);
    assign stop_seen   = seq_q.stop_seen;
    assign irq_flag    = seq_q.irq;
    assign wcol_flag   = seq_q.wcol;
    assign buf_q       = seq_q.buf_data;

    // R2: during the low phase SCL is held and SDA carries the stored bit
    p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ACK_LOW) |-> (!scl_oe && (sda_oe == seq_q.ack_bit)));

    // R3: no progress past the release point without a high SCL sample
    p_ack_wait_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_ACK_REL) && !scl_s |=> (seq_q.st == ST_ACK_REL) && scl_oe);

    // R6: SDA rises in a Stop only while SCL is released
    p_stop_sda_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_active && $rose(sda_oe) |-> scl_oe);

    // R7: stop_seen follows a sample of both lines high
    p_stop_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_seen) |-> $past(sda_s && scl_s));

    // R8: busy-time buffer write is refused and flagged
    p_wcol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr && (ack_active || stop_active) |=> wcol_flag && $stable(buf_q));

    // R9: interrupt flag stays set without a clear
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !irq_clr |=> irq_flag);

    // R10: a request during a Stop never starts an acknowledge
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_active && ack_go |=> !ack_active);

endmodule

// File: tb/i2c_ackstop_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_ackstop_seq_tb_top;
    localparam int CNT_W = 8;
    localparam int BUF_W = 8;
    localparam int S     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] reload = '0;
    logic             ack_go = 0, ack_bit = 0, stop_go = 0, buf_wr = 0;
    logic [BUF_W-1:0] buf_wdata = '0;
    logic             irq_clr = 0, wcol_clr = 0;
    logic             hold = 0;
    logic             sda_in, scl_in;
    logic             sda_oe, scl_oe, ack_active, stop_active, stop_seen;
    logic             irq_flag, wcol_flag;
    logic [BUF_W-1:0] buf_q;

    int checks = 0;
    int fails  = 0;
    logic [BUF_W-1:0] exp_buf = '0;

    always #2.5 clk = ~clk;

    assign sda_in = sda_oe;
    assign scl_in = scl_oe & ~hold;

    i2c_ackstop_seq #(.CNT_W(CNT_W), .BUF_W(BUF_W), .SYNC_STAGES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .reload(reload), .ack_go(ack_go), .ack_bit(ack_bit),
        .stop_go(stop_go), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .irq_clr(irq_clr),
        .wcol_clr(wcol_clr), .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe),
        .scl_oe(scl_oe), .ack_active(ack_active), .stop_active(stop_active),
        .stop_seen(stop_seen), .irq_flag(irq_flag), .wcol_flag(wcol_flag), .buf_q(buf_q)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((ack_active || stop_active) && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        check("R9 irq cleared", irq_flag, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 sda_oe", sda_oe, 1);
        check("R1 scl_oe", scl_oe, 1);
        check("R1 flags", {stop_seen, irq_flag, wcol_flag, ack_active, stop_active}, 0);
        check("R1 buf", buf_q, 0);
    endtask

    task automatic t_buf_idle(logic [BUF_W-1:0] v);
        @(negedge clk);
        buf_wr = 1; buf_wdata = v;
        @(negedge clk);
        buf_wr = 0;
        exp_buf = v;
        check("R11 idle write", buf_q, v);
    endtask

    task automatic run_ack(int r, bit b, int k);
        int n;
        clear_irq();
        reload = r[CNT_W-1:0];
        hold = (k > 0);
        ack_bit = b; ack_go = 1;
        @(negedge clk);
        ack_go = 0;
        check("R7 stop_seen cleared at start", stop_seen, 0);
        n = 0;
        while (scl_oe == 0 && n < 1000) begin
            check("R2 sda carries ack_bit", sda_oe, b);
            n++;
            @(negedge clk);
        end
        check("R2 low phase length", n, r + 1);
        if (k > 0) begin
            repeat (k) begin
                check("R3 held while stretched", {scl_oe, ack_active}, 2'b11);
                @(negedge clk);
            end
            #1 hold = 0;
            @(negedge clk);
            n = 0;
            while (scl_oe == 1 && n < 1000) begin n++; @(negedge clk); end
            check("R3 stretched high length", n, r + S + 1);
        end else begin
            n = 0;
            while (scl_oe == 1 && n < 1000) begin n++; @(negedge clk); end
            check("R3 high length", n, r + S + 2);
        end
        check("R4 ack_active cleared", ack_active, 0);
        check("R4 irq set", irq_flag, 1);
        check("R4 scl low", scl_oe, 0);
    endtask

    task automatic run_stop(int r, bit sda_was_low);
        int n;
        clear_irq();
        reload = r[CNT_W-1:0];
        stop_go = 1;
        @(negedge clk);
        stop_go = 0;
        n = 0;
        while (!sda_oe && !scl_oe && n < 1000) begin n++; @(negedge clk); end
        check("R5 sda-low phase", n, sda_was_low ? r + 2 : r + S + 2);
        n = 0;
        while (scl_oe && !sda_oe && n < 1000) begin n++; @(negedge clk); end
        check("R6 scl-high phase", n, r + S + 2);
        check("R6 scl still released", scl_oe, 1);
        n = 0;
        while (sda_oe && !stop_seen && n < 1000) begin n++; @(negedge clk); end
        check("R7 stop_seen delay", n, S + 1);
        n = 0;
        while (stop_seen && stop_active && n < 1000) begin n++; @(negedge clk); end
        check("R7 end delay", n, r + 1);
        check("R7 irq set", irq_flag, 1);
        check("R7 stop_active cleared", stop_active, 0);
        check("R7 lines released", {sda_oe, scl_oe}, 2'b11);
    endtask

    task automatic t_wcol();
        reload = 6;
        @(negedge clk);
        ack_bit = 0; ack_go = 1;
        @(negedge clk);
        ack_go = 0;
        @(negedge clk);
        buf_wr = 1; buf_wdata = 8'hA5;
        @(negedge clk);
        buf_wr = 0;
        check("R8 wcol set", wcol_flag, 1);
        check("R8 buf unchanged", buf_q, exp_buf);
        buf_wr = 1; buf_wdata = 8'h11; wcol_clr = 1;
        @(negedge clk);
        buf_wr = 0; wcol_clr = 0;
        check("R9 set beats clear", wcol_flag, 1);
        wait_idle();
        t_buf_idle(8'h3C);
        check("R9 wcol sticky", wcol_flag, 1);
        wcol_clr = 1;
        @(negedge clk);
        wcol_clr = 0;
        check("R9 wcol cleared", wcol_flag, 0);
    endtask

    task automatic t_busy();
        reload = 3;
        @(negedge clk);
        ack_bit = 1; ack_go = 1;
        @(negedge clk);
        ack_go = 0;
        stop_go = 1;
        @(negedge clk);
        stop_go = 0;
        check("R10 stop ignored during ack", stop_active, 0);
        wait_idle();
        repeat (4) @(negedge clk);
        check("R10 no stop after ack", {stop_active, scl_oe}, 0);
        ack_go = 1; stop_go = 1;
        @(negedge clk);
        ack_go = 0; stop_go = 0;
        check("R10 ack wins", {ack_active, stop_active}, 2'b10);
        wait_idle();
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_buf_idle(8'h5A);
        run_ack(3, 1'b0, 0);
        run_stop(5, 1'b1);
        run_ack(4, 1'b1, 12);
        run_ack(2, 1'b1, 0);
        run_stop(2, 1'b0);
        t_wcol();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule